// File: doc/BRIEF.md
# Software Watchdog Timer with Selectable Expiry Response

This block guards a processor against software that has run away into an endless loop, and against a bus access that never completes. While it is enabled, a counter advances on every clock. Software keeps the counter from reaching its limit by writing a fixed two-value key to the service register at regular intervals. If the limit is reached first, the watchdog responds in one of two ways, chosen in the control register. It either sets a sticky flag that drives an interrupt line toward the core, or it issues a one-cycle request for an immediate system reset.

The block has a narrow register port: a write strobe with a 2-bit address and a data word, and a read address that returns one register combinationally. The watchdog is off after reset. The write that enables it also fixes the period and the response mode, and from then on the control register cannot be changed until the next reset. Locking the control register keeps faulty software from quietly disabling its own guard.

Top module: `wdog_core`

## Requirements
- R1: After reset the control register reads 0, the service-sequence state reads 0, the status flag reads 0, `irq` is low and `rst_req` is low.
- R2: Control register (address 0) bit 0 enables the watchdog. While it is 0 the counter stays at zero, and neither `irq` nor `rst_req` is ever asserted, whatever the period setting is.
- R3: Control bits [3:2] hold a period code k. The period is 2^(BASE_LOG + STEP_LOG*k) clocks, which by default gives 2^8, 2^12, 2^16 and 2^20. The timer expires on the clock edge that is exactly one period after the edge that enabled it or last reloaded it.
- R4: Writing 0x55 to the service register (address 1) and then 0xAA reloads the counter to zero. Other register writes or idle cycles may fall between the two key writes. After a reload a full period must pass before the next expiry.
- R5: A service write of any value other than 0x55 or 0xAA returns the sequence to its start. So does 0xAA written without a pending 0x55. Such writes do not reload the counter.
- R6: With control bit 1 at 0 (interrupt mode), expiry sets a sticky flag. The flag is read at address 2 bit 0 and drives `irq`. The flag stays set, and the counter starts a new period from zero.
- R7: Writing address 2 with bit 0 set clears the flag. Writing address 2 with bit 0 clear leaves the flag unchanged.
- R8: With control bit 1 at 1 (reset mode), each expiry drives `rst_req` high for exactly one clock, in the cycle after the expiry edge. The flag is not set, and expiries repeat once per period.
- R9: Once the enable bit is 1, writes to the control register are ignored until reset. Before that, the control register may be rewritten freely.
- R10: Address 1 bit 0 reads 1 while a 0x55 is pending, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter advances once per edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 service, 2 status |
| wr_data | input | DW | Write data |
| rd_addr | input | 2 | Read address, same map as the write address |
| rd_data | output | DW | Combinational read data |
| irq | output | 1 | Interrupt request, equal to the sticky flag |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The hardest cases to reach from the ports are timing races between servicing and expiry. One is a broken key sequence that must leave the counter's phase alone. Another is a period that must restart exactly at the expiry edge. Neither leaves any trace at the ports until much later. The bench builds the block with short periods and runs a clock-by-clock behavioural model beside it. It measures the distance between a reload or an expiry and the next event. It inserts bad keys partway through a period, so that a wrong reload shows up as a late interrupt. Mode and period changes that need a fresh unlock are reached by resetting the block in the middle of the run.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   typedef enum logic [1:0] {
      ADDR_CTRL = 2'd0,
      ADDR_SVC  = 2'd1,
      ADDR_STAT = 2'd2
   } wd_addr_t;

   typedef struct packed {
      logic [3:0] rsvd;
      logic [1:0] tsel;
      logic       mode;
      logic       en;
   } wd_ctrl_t;

   localparam logic [7:0] KEY_FIRST  = 8'h55;
   localparam logic [7:0] KEY_SECOND = 8'hAA;
   localparam int unsigned NUM_PERIODS = 4;

endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
   import wdog_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_stb,
   input  logic [3:0] wr_bits,
   output wd_ctrl_t   ctrl_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_stb && !ctrl_q.en) begin
         ctrl_q.en   <= wr_bits[0];
         ctrl_q.mode <= wr_bits[1];
         ctrl_q.tsel <= wr_bits[3:2];
         ctrl_q.rsvd <= '0;
      end
   end

endmodule

// File: rtl/wdog_svc_seq.sv
module wdog_svc_seq
   import wdog_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_stb,
   input  logic [DW-1:0] wr_data,
   output logic          armed_q,
   output logic          reload
);

   localparam logic [DW-1:0] K1 = DW'(KEY_FIRST);
   localparam logic [DW-1:0] K2 = DW'(KEY_SECOND);

   logic is_k1;
   logic is_k2;

   assign is_k1  = (wr_data == K1);
   assign is_k2  = (wr_data == K2);
   assign reload = wr_stb && armed_q && is_k2;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (wr_stb) begin
         armed_q <= is_k1;
      end
   end

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
   import wdog_pkg::*;
#(
   parameter int unsigned BASE_LOG = 8,
   parameter int unsigned STEP_LOG = 4,
   localparam int unsigned CNT_W   = BASE_LOG + STEP_LOG * (NUM_PERIODS - 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [1:0]       tsel,
   input  logic             reload,
   output logic             expire,
   output logic [CNT_W-1:0] cnt_q
);

   logic [NUM_PERIODS-1:0] hit;

   for (genvar gi = 0; gi < NUM_PERIODS; gi++) begin : g_lim
      localparam int unsigned LG = BASE_LOG + STEP_LOG * gi;
      localparam logic [CNT_W-1:0] LIM = CNT_W'((1 << LG) - 1);
      assign hit[gi] = (cnt_q == LIM);
   end

   assign expire = en && hit[tsel] && !reload;

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         cnt_q <= '0;
      end else if (reload || expire) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

endmodule

// File: rtl/wdog_resp.sv
module wdog_resp (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic mode,
   input  logic clr_stb,
   output logic flag_q,
   output logic rst_req_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q    <= 1'b0;
         rst_req_q <= 1'b0;
      end else begin
         rst_req_q <= expire && mode;
         if (expire && !mode) begin
            flag_q <= 1'b1;
         end else if (clr_stb) begin
            flag_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/wdog_core.sv
module wdog_core
   import wdog_pkg::*;
#(
   parameter int unsigned DW       = 8,
   parameter int unsigned BASE_LOG = 8,
   parameter int unsigned STEP_LOG = 4,
   localparam int unsigned CNT_W   = BASE_LOG + STEP_LOG * (NUM_PERIODS - 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [1:0]    rd_addr,
   output logic [DW-1:0] rd_data,
   output logic          irq,
   output logic          rst_req
);

   if (DW < 8) begin : g_bad_dw
      $error("wdog_core: DW must be at least 8");
   end
   if (BASE_LOG < 2) begin : g_bad_base
      $error("wdog_core: BASE_LOG must be at least 2");
   end
   if (CNT_W > 30) begin : g_bad_cnt
      $error("wdog_core: longest period exceeds 2^30");
   end

   wd_ctrl_t         ctrl_q;
   logic             armed;
   logic             reload;
   logic             expire;
   logic             flag;
   logic [CNT_W-1:0] cnt;
   logic             ctrl_stb;
   logic             svc_stb;
   logic             clr_stb;

   assign ctrl_stb = wr_en && (wr_addr == ADDR_CTRL);
   assign svc_stb  = wr_en && (wr_addr == ADDR_SVC);
   assign clr_stb  = wr_en && (wr_addr == ADDR_STAT) && wr_data[0];

   wdog_ctrl_reg u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (ctrl_stb),
      .wr_bits (wr_data[3:0]),
      .ctrl_q  (ctrl_q)
   );

   wdog_svc_seq #(.DW(DW)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (svc_stb),
      .wr_data (wr_data),
      .armed_q (armed),
      .reload  (reload)
   );

   wdog_timer #(.BASE_LOG(BASE_LOG), .STEP_LOG(STEP_LOG)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (ctrl_q.en),
      .tsel   (ctrl_q.tsel),
      .reload (reload),
      .expire (expire),
      .cnt_q  (cnt)
   );

   wdog_resp u_resp (
      .clk       (clk),
      .rst_n     (rst_n),
      .expire    (expire),
      .mode      (ctrl_q.mode),
      .clr_stb   (clr_stb),
      .flag_q    (flag),
      .rst_req_q (rst_req)
   );

   assign irq = flag;

   always_comb begin
      case (wd_addr_t'(rd_addr))
         ADDR_CTRL: rd_data = DW'(ctrl_q);
         ADDR_SVC:  rd_data = DW'(armed);
         ADDR_STAT: rd_data = DW'(flag);
         default:   rd_data = '0;
      endcase
   end

endmodule

// File: rtl/wdog_core_chk.sv
module wdog_core_chk #(
   parameter int unsigned DW    = 8,
   parameter int unsigned CNT_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       wr_addr,
   input logic [DW-1:0]    wr_data,
   input logic             irq,
   input logic             rst_req,
   input logic [7:0]       ctrl,
   input logic             armed,
   input logic [CNT_W-1:0] cnt
);

   logic key2_wr;
   logic clr_wr;
   assign key2_wr = wr_en && (wr_addr == 2'd1) && (wr_data == DW'(8'hAA));
   assign clr_wr  = wr_en && (wr_addr == 2'd2) && wr_data[0];

   p_quiet_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl[0] |-> (cnt == '0) && !irq && !rst_req);

   p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl[0] && armed && key2_wr |=> (cnt == '0));

   p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !clr_wr |=> irq);

   p_one_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   p_no_irq_in_rst_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl[1] |-> !irq);

   p_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl[0] |=> $stable(ctrl));

endmodule

bind wdog_core wdog_core_chk #(.DW(DW), .CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .irq     (irq),
   .rst_req (rst_req),
   .ctrl    (ctrl_q),
   .armed   (armed),
   .cnt     (cnt)
);

// File: tb/sim_wdog_core.sv
module sim_wdog_core;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 8;
   localparam int BL = 4;
   localparam int SL = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_addr = 2'd0;
   logic [DW-1:0] wr_data = '0;
   logic [1:0]    rd_addr = 2'd0;
   logic [DW-1:0] rd_data;
   logic          irq;
   logic          rst_req;

   int checks = 0;
   int failures = 0;
   bit started = 0;

   // behavioural model state
   int m_en = 0, m_mode = 0, m_tsel = 0, m_cnt = 0;
   int m_armed = 0, m_flag = 0, m_rq = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wdog_core #(.DW(DW), .BASE_LOG(BL), .STEP_LOG(SL)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .irq(irq), .rst_req(rst_req)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      int period, n_cnt, n_flag, n_rq, n_armed, n_en, n_mode, n_tsel;
      bit rl, ex;
      started = 1;
      if (!rst_n) begin
         m_en = 0; m_mode = 0; m_tsel = 0; m_cnt = 0;
         m_armed = 0; m_flag = 0; m_rq = 0;
      end else begin
         period = 1 << (BL + SL * m_tsel);
         rl = wr_en && wr_addr == 2'd1 && m_armed == 1 && wr_data == 8'hAA;
         ex = (m_en == 1) && (m_cnt == period - 1) && !rl;
         n_cnt = (m_en == 0 || rl || ex) ? 0 : m_cnt + 1;
         n_rq = (ex && m_mode == 1) ? 1 : 0;
         n_flag = m_flag;
         if (ex && m_mode == 0) n_flag = 1;
         else if (wr_en && wr_addr == 2'd2 && wr_data[0]) n_flag = 0;
         n_armed = m_armed;
         if (wr_en && wr_addr == 2'd1) n_armed = (wr_data == 8'h55) ? 1 : 0;
         n_en = m_en; n_mode = m_mode; n_tsel = m_tsel;
         if (wr_en && wr_addr == 2'd0 && m_en == 0) begin
            n_en = wr_data[0]; n_mode = wr_data[1]; n_tsel = wr_data[3:2];
         end
         m_cnt = n_cnt; m_rq = n_rq; m_flag = n_flag; m_armed = n_armed;
         m_en = n_en; m_mode = n_mode; m_tsel = n_tsel;
      end
   end

   always @(negedge clk) begin
      int exp_rd;
      if (started) begin
         case (rd_addr)
            2'd0: exp_rd = (m_tsel << 2) | (m_mode << 1) | m_en;
            2'd1: exp_rd = m_armed;
            2'd2: exp_rd = m_flag;
            default: exp_rd = 0;
         endcase
         chk("R6 model irq", int'(irq), m_flag);
         chk("R8 model rst_req", int'(rst_req), m_rq);
         chk("R10 model rd_data", int'(rd_data), exp_rd);
      end
   end

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); #1;
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      rd_addr = a; #2;
      v = int'(rd_data);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk); #1; rst_n = 1'b0;
      @(negedge clk); #1; rst_n = 1'b1;
   endtask

   task automatic wait_irq(output int n);
      n = 0;
      while (!irq && n < 5000) begin @(negedge clk); n++; end
      #1;
   endtask

   task automatic wait_rq(output int n);
      n = 0;
      while (!rst_req && n < 5000) begin @(negedge clk); n++; end
      #1;
   endtask

   initial begin
      int v, n;
      idle(3);
      @(negedge clk); #1; rst_n = 1'b1;
      idle(1);
      // R1 reset state
      rd(2'd0, v); chk("R1 ctrl after reset", v, 0);
      rd(2'd1, v); chk("R1 seq after reset", v, 0);
      rd(2'd2, v); chk("R1 flag after reset", v, 0);
      chk("R1 irq after reset", int'(irq), 0);
      chk("R1 rst_req after reset", int'(rst_req), 0);
      // R2 disabled, shortest period written but not enabled; R9 still writable
      wr(2'd0, 8'h02);
      rd(2'd0, v); chk("R9 ctrl writable while off", v, 2);
      wr(2'd0, 8'h00);
      idle(60);
      chk("R2 no irq while off", int'(irq), 0);
      // R10 / R5 sequence state
      wr(2'd1, 8'h55); rd(2'd1, v); chk("R10 pending after 0x55", v, 1);
      wr(2'd1, 8'h12); rd(2'd1, v); chk("R5 other value restarts", v, 0);
      wr(2'd1, 8'hAA); rd(2'd1, v); chk("R5 lone 0xAA stays idle", v, 0);
      // R3 / R6 interrupt mode, code 0
      wr(2'd0, 8'h01);
      wait_irq(n); chk("R3 period code0", n, 16);
      idle(5);
      chk("R6 flag sticky", int'(irq), 1);
      wr(2'd2, 8'h00); chk("R7 write 0 keeps flag", int'(irq), 1);
      wr(2'd2, 8'h01); chk("R7 write 1 clears flag", int'(irq), 0);
      // R9 lock
      wr(2'd0, 8'h0E);
      rd(2'd0, v); chk("R9 ctrl locked", v, 1);
      // R4 reload timing
      wr(2'd1, 8'h55); wr(2'd1, 8'hAA);
      wait_irq(n); chk("R4 full period after reload", n, 16);
      wr(2'd2, 8'h01);
      // R4 periodic service keeps irq low
      for (int i = 0; i < 8; i++) begin
         wr(2'd1, 8'h55); idle(2); wr(2'd1, 8'hAA); idle(4);
      end
      chk("R4 serviced no irq", int'(irq), 0);
      // R5 broken key does not reload
      wr(2'd1, 8'h55); wr(2'd1, 8'hAA);
      idle(4);
      wr(2'd1, 8'h55); wr(2'd1, 8'h33); wr(2'd1, 8'hAA);
      wait_irq(n);
      chk("R5 broken key no reload", (n < 16) ? 1 : 0, 1);
      // R3 code 2 after fresh reset
      do_reset();
      rd(2'd0, v); chk("R1 ctrl cleared by reset", v, 0);
      wr(2'd0, 8'h09);
      wait_irq(n); chk("R3 period code2", n, 256);
      // R8 reset mode code 1
      do_reset();
      wr(2'd0, 8'h07);
      wait_rq(n); chk("R3 period code1", n, 64);
      chk("R8 no irq in reset mode", int'(irq), 0);
      @(negedge clk); #1;
      chk("R8 pulse one cycle", int'(rst_req), 0);
      wait_rq(n); chk("R8 repeats each period", n, 63);
      idle(3);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog timeout actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule